// File: doc/BRIEF.md
# Dual-Reload Multimode Down-Counter Timer

This block is a 16-bit timer that counts down from a loaded value and works in one of three ways. In waveform mode it alternates between two reload values, A and B, so that one value sets the high time of an output and the other sets the low time. In event mode it counts down once for each chosen edge seen on an input pin. In capture mode it counts down on every clock and copies the running count into A or B when a chosen edge arrives on one of two input pins.

Each of the two sources, A and B, has a sticky pending flag and an enable. The block raises its own interrupt line for each source. Software uses a small synchronous register port to reach the counter, both reload/capture registers and one control word. The input pins go through a two-flop synchroniser before edge detection.

The control state machine has five states. In `ST_IDLE` the counter is stopped. `ST_PWM_HI` drives the output high and `ST_PWM_LO` drives it low. `ST_EVT` counts input edges and `ST_CAP` captures the count. The transitions are as follows:
- The state falls to idle whenever the run bit is clear or the mode code is not valid.
- On entry to waveform mode the state goes to the high state.
- The state moves between the high and low states when the counter underflows.
- The valid event and capture codes lead straight to their own states.

Top module: `dual_reload_timer`

## Requirements
- R1: After reset the counter, A, B and the control word read as zero, and `pwm_out`, `irq_a` and `irq_b` are low.
- R2: Register addresses are: 0 the counter, 1 register A, 2 register B, 3 control. A write takes effect at the next clock edge. A read is combinational. A software write to the counter, A or B overrides any hardware update in the same cycle. The control word bits are:
  - mode[2:0]
  - run at bit 3
  - enable A at bit 4
  - enable B at bit 5
  - pending A at bit 6
  - pending B at bit 7
  - falling-edge select for pin A at bit 8
  - falling-edge select for pin B at bit 9
  - all other bits read as zero.
- R3: The mode codes are 001 for waveform, 010 for event count and 011 for capture. With run clear, or with any other mode code, the state is idle and the counter holds its value.
- R4: In waveform mode the counter decrements every clock. When the count reaches zero in the high state, the block loads B, sets pending B and moves to the low state. When the count reaches zero in the low state, the block loads A, sets pending A and moves to the high state.
- R5: `pwm_out` is high only in the high state. Entering waveform mode always starts in the high state, one cycle after the control write.
- R6: In event mode the counter changes only on a qualified edge of `ev_a_in`. A qualified edge is rising when bit 8 is 0 and falling when bit 8 is 1, and it is seen after two synchroniser flops. On a qualified edge the counter decrements, or, if it was zero, loads A and sets pending A.
- R7: In capture mode the counter decrements every clock and wraps from 0 to FFFF. A qualified edge on `ev_a_in` copies the pre-edge count into A and sets pending A. A qualified edge on `ev_b_in` (edge select at bit 9) does the same into B and sets pending B.
- R8: Pending flags stay set until a control write with a 1 in the flag's bit position. A hardware set in the same cycle wins over that clear.
- R9: `irq_a` is high exactly when pending A and enable A are both set. `irq_b` is high exactly when pending B and enable B are both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register select |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr` |
| ev_a_in | input | 1 | Event / capture pin A (asynchronous) |
| ev_b_in | input | 1 | Capture pin B (asynchronous) |
| pwm_out | output | 1 | Waveform output |
| irq_a | output | 1 | Source A interrupt |
| irq_b | output | 1 | Source B interrupt |

## Verification
The assertions assume that the pins change no faster than the synchroniser can follow, so every level lasts at least three clocks and each transition yields one edge pulse. They also assume that software writes at most one register per cycle. The stimulus holds each pin level for four clocks, issues single-cycle writes only, and changes the mode only by a full control write. This means every state transition is taken from a known control word. A behavioural model in the bench predicts the outputs and the addressed register every cycle.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PWM_HI,
        ST_PWM_LO,
        ST_EVT,
        ST_CAP
    } tmr_state_t;

    localparam logic [2:0] MODE_PWM = 3'b001;
    localparam logic [2:0] MODE_EVT = 3'b010;
    localparam logic [2:0] MODE_CAP = 3'b011;

    localparam int BIT_RUN    = 3;
    localparam int BIT_EN_A   = 4;
    localparam int BIT_EN_B   = 5;
    localparam int BIT_PEND_A = 6;
    localparam int BIT_PEND_B = 7;
    localparam int BIT_FALL_A = 8;
    localparam int BIT_FALL_B = 9;
    localparam int CTL_BITS   = 10;

    localparam logic [1:0] ADDR_CNT = 2'd0;
    localparam logic [1:0] ADDR_A   = 2'd1;
    localparam logic [1:0] ADDR_B   = 2'd2;
    localparam logic [1:0] ADDR_CTL = 2'd3;
endpackage

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic fall_sel,
    output logic hit
);
    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], pin};
            prev_q <= sync_q[STAGES-1];
        end
    end

    assign hit = fall_sel ? (prev_q & ~sync_q[STAGES-1])
                          : (sync_q[STAGES-1] & ~prev_q);
endmodule

// File: rtl/tmr_fsm.sv
module tmr_fsm
    import tmr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic [2:0] mode,
    input  logic       zero,
    output tmr_state_t state
);
    tmr_state_t state_d;
    logic       active;

    assign active = run && (mode == MODE_PWM || mode == MODE_EVT || mode == MODE_CAP);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_d;
    end

    always_comb begin
        state_d = ST_IDLE;
        if (active) begin
            unique case (mode)
                MODE_PWM: begin
                    if (state == ST_PWM_HI)      state_d = zero ? ST_PWM_LO : ST_PWM_HI;
                    else if (state == ST_PWM_LO) state_d = zero ? ST_PWM_HI : ST_PWM_LO;
                    else                         state_d = ST_PWM_HI;
                end
                MODE_EVT: state_d = ST_EVT;
                MODE_CAP: state_d = ST_CAP;
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    a_r4_hi_to_lo: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PWM_HI && zero && run && mode == MODE_PWM) |=> (state == ST_PWM_LO));
    a_r3_stop_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!run) |=> (state == ST_IDLE));
    a_r5_enter_high: assert property (@(posedge clk) disable iff (!rst_n)
        (run && mode == MODE_PWM && state != ST_PWM_HI && state != ST_PWM_LO)
        |=> (state == ST_PWM_HI));
endmodule

// File: rtl/dual_reload_timer.sv
module dual_reload_timer
    import tmr_pkg::*;
#(
    parameter int W         = 16,
    parameter int AW        = 2,
    parameter int SYNC_STGS = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  rdata,
    input  logic          ev_a_in,
    input  logic          ev_b_in,
    output logic          pwm_out,
    output logic          irq_a,
    output logic          irq_b
);
    localparam int         NSRC = 2;
    localparam logic [W-1:0] ONE = W'(1);

    logic [W-1:0] cnt_q, rel_a_q, rel_b_q, cnt_d, rel_a_d, rel_b_d;
    logic [2:0]   mode_q;
    logic         run_q, en_a_q, en_b_q, pend_a_q, pend_b_q, fall_a_q, fall_b_q;
    logic         set_a, set_b, zero;
    logic         wr_cnt, wr_a, wr_b, wr_ctl;
    logic [NSRC-1:0] pins, fall_sel, hit;
    tmr_state_t   st;
    wire          unused_ctl_bits = ^wdata[W-1:CTL_BITS];

    assign zero   = (cnt_q == '0);
    assign wr_cnt = wr_en && (addr == ADDR_CNT);
    assign wr_a   = wr_en && (addr == ADDR_A);
    assign wr_b   = wr_en && (addr == ADDR_B);
    assign wr_ctl = wr_en && (addr == ADDR_CTL);

    assign pins     = {ev_b_in, ev_a_in};
    assign fall_sel = {fall_b_q, fall_a_q};

    for (genvar i = 0; i < NSRC; i++) begin : g_sync
        tmr_edge_sync #(.STAGES(SYNC_STGS)) u_sync (
            .clk      (clk),
            .rst_n    (rst_n),
            .pin      (pins[i]),
            .fall_sel (fall_sel[i]),
            .hit      (hit[i])
        );
    end

    tmr_fsm u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run_q),
        .mode  (mode_q),
        .zero  (zero),
        .state (st)
    );

    always_comb begin
        cnt_d   = cnt_q;
        rel_a_d = rel_a_q;
        rel_b_d = rel_b_q;
        set_a   = 1'b0;
        set_b   = 1'b0;
        unique case (st)
            ST_PWM_HI: begin
                if (zero) begin cnt_d = rel_b_q; set_b = 1'b1; end
                else          cnt_d = cnt_q - ONE;
            end
            ST_PWM_LO: begin
                if (zero) begin cnt_d = rel_a_q; set_a = 1'b1; end
                else          cnt_d = cnt_q - ONE;
            end
            ST_EVT: begin
                if (hit[0]) begin
                    if (zero) begin cnt_d = rel_a_q; set_a = 1'b1; end
                    else          cnt_d = cnt_q - ONE;
                end
            end
            ST_CAP: begin
                cnt_d = cnt_q - ONE;
                if (hit[0]) begin rel_a_d = cnt_q; set_a = 1'b1; end
                if (hit[1]) begin rel_b_d = cnt_q; set_b = 1'b1; end
            end
            default: ;
        endcase
        if (wr_cnt) cnt_d   = wdata;
        if (wr_a)   rel_a_d = wdata;
        if (wr_b)   rel_b_d = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            rel_a_q  <= '0;
            rel_b_q  <= '0;
            mode_q   <= '0;
            run_q    <= 1'b0;
            en_a_q   <= 1'b0;
            en_b_q   <= 1'b0;
            pend_a_q <= 1'b0;
            pend_b_q <= 1'b0;
            fall_a_q <= 1'b0;
            fall_b_q <= 1'b0;
        end else begin
            cnt_q    <= cnt_d;
            rel_a_q  <= rel_a_d;
            rel_b_q  <= rel_b_d;
            pend_a_q <= set_a | (pend_a_q & ~(wr_ctl & wdata[BIT_PEND_A]));
            pend_b_q <= set_b | (pend_b_q & ~(wr_ctl & wdata[BIT_PEND_B]));
            if (wr_ctl) begin
                mode_q   <= wdata[2:0];
                run_q    <= wdata[BIT_RUN];
                en_a_q   <= wdata[BIT_EN_A];
                en_b_q   <= wdata[BIT_EN_B];
                fall_a_q <= wdata[BIT_FALL_A];
                fall_b_q <= wdata[BIT_FALL_B];
            end
        end
    end

    always_comb begin
        unique case (addr)
            ADDR_CNT: rdata = cnt_q;
            ADDR_A:   rdata = rel_a_q;
            ADDR_B:   rdata = rel_b_q;
            default:  rdata = {{(W-CTL_BITS){1'b0}}, fall_b_q, fall_a_q, pend_b_q, pend_a_q,
                               en_b_q, en_a_q, run_q, mode_q};
        endcase
    end

    assign pwm_out = (st == ST_PWM_HI);
    assign irq_a   = pend_a_q & en_a_q;
    assign irq_b   = pend_b_q & en_b_q;

    a_r4_reload_b: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_PWM_HI && zero && !wr_cnt) |=> (cnt_q == $past(rel_b_q)));
    a_r3_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && !wr_cnt) |=> $stable(cnt_q));
    a_r6_evt_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_EVT && !hit[0] && !wr_cnt) |=> $stable(cnt_q));
    a_r7_capture_a: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_CAP && hit[0] && !wr_a) |=> (rel_a_q == $past(cnt_q)));
    a_r8_pend_a_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_a_q && !(wr_ctl && wdata[BIT_PEND_A])) |=> pend_a_q);
    a_r8_pend_b_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_b_q && !(wr_ctl && wdata[BIT_PEND_B])) |=> pend_b_q);
    a_r9_irq_needs_pend: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_a) |-> (pend_a_q && $past(set_a || en_a_q != pend_a_q || wr_ctl)));
endmodule

// File: tb/dual_reload_timer_tb.sv
module dual_reload_timer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        ev_a = 1'b0, ev_b = 1'b0;
    logic        pwm_out, irq_a, irq_b;

    int checks = 0, fails = 0;
    bit done = 0;

    always #5 clk = ~clk;

    dual_reload_timer u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .ev_a_in(ev_a), .ev_b_in(ev_b),
        .pwm_out(pwm_out), .irq_a(irq_a), .irq_b(irq_b)
    );

    // Behavioural reference model
    logic [15:0] m_cnt, m_a, m_b, n_cnt, n_a, n_b;
    logic [2:0]  m_mode;
    bit m_run, m_ena, m_enb, m_pa, m_pb, m_fa, m_fb;
    bit m_s1a, m_s2a, m_s3a, m_s1b, m_s2b, m_s3b;
    bit hit_a, hit_b, sa, sb, z, valid;
    int m_st, nst; // 0 idle, 1 high, 2 low, 3 event, 4 capture

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_a = 0; m_b = 0; m_mode = 0; m_st = 0;
            m_run = 0; m_ena = 0; m_enb = 0; m_pa = 0; m_pb = 0; m_fa = 0; m_fb = 0;
            m_s1a = 0; m_s2a = 0; m_s3a = 0; m_s1b = 0; m_s2b = 0; m_s3b = 0;
        end else begin
            hit_a = m_fa ? (m_s3a && !m_s2a) : (m_s2a && !m_s3a);
            hit_b = m_fb ? (m_s3b && !m_s2b) : (m_s2b && !m_s3b);
            m_s3a = m_s2a; m_s2a = m_s1a; m_s1a = ev_a;
            m_s3b = m_s2b; m_s2b = m_s1b; m_s1b = ev_b;
            z = (m_cnt == 0);
            valid = m_run && (m_mode == 1 || m_mode == 2 || m_mode == 3);
            if (!valid) nst = 0;
            else if (m_mode == 1) nst = (m_st == 1) ? (z ? 2 : 1) : (m_st == 2) ? (z ? 1 : 2) : 1;
            else if (m_mode == 2) nst = 3;
            else nst = 4;
            n_cnt = m_cnt; n_a = m_a; n_b = m_b; sa = 0; sb = 0;
            case (m_st)
                1: if (z) begin n_cnt = m_b; sb = 1; end else n_cnt = m_cnt - 16'd1;
                2: if (z) begin n_cnt = m_a; sa = 1; end else n_cnt = m_cnt - 16'd1;
                3: if (hit_a) begin
                       if (z) begin n_cnt = m_a; sa = 1; end else n_cnt = m_cnt - 16'd1;
                   end
                4: begin
                       n_cnt = m_cnt - 16'd1;
                       if (hit_a) begin n_a = m_cnt; sa = 1; end
                       if (hit_b) begin n_b = m_cnt; sb = 1; end
                   end
                default: ;
            endcase
            if (wr_en && addr == 0) n_cnt = wdata;
            if (wr_en && addr == 1) n_a = wdata;
            if (wr_en && addr == 2) n_b = wdata;
            m_pa = sa || (m_pa && !(wr_en && addr == 3 && wdata[6]));
            m_pb = sb || (m_pb && !(wr_en && addr == 3 && wdata[7]));
            if (wr_en && addr == 3) begin
                m_mode = wdata[2:0]; m_run = wdata[3]; m_ena = wdata[4];
                m_enb = wdata[5]; m_fa = wdata[8]; m_fb = wdata[9];
            end
            m_cnt = n_cnt; m_a = n_a; m_b = n_b; m_st = nst;
        end
    end

    function automatic logic [15:0] exp_rd(input logic [1:0] a);
        case (a)
            2'd0: return m_cnt;
            2'd1: return m_a;
            2'd2: return m_b;
            default: return {6'b0, m_fb, m_fa, m_pb, m_pa, m_enb, m_ena, m_run, m_mode};
        endcase
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s at %0t: actual %h expected %h", req, $time, act, exp);
        end
    endtask

    // Compare on every clock, at the falling edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(m_st == 1 ? "R5 pwm_out" : "R4 pwm_out", {15'b0, pwm_out}, {15'b0, m_st == 1});
            check("R9 irq_a", {15'b0, irq_a}, {15'b0, m_pa && m_ena});
            check("R9 irq_b", {15'b0, irq_b}, {15'b0, m_pb && m_enb});
            if (addr == 3)       check("R8 ctl", rdata, exp_rd(addr));
            else if (m_st == 3)  check("R6 reg", rdata, exp_rd(addr));
            else if (m_st == 4)  check("R7 reg", rdata, exp_rd(addr));
            else if (m_st == 0)  check("R3 reg", rdata, exp_rd(addr));
            else                 check("R2 reg", rdata, exp_rd(addr));
        end
    end

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk); #1;
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); #1;
            addr = 2'(i % 4);
        end
    endtask

    task automatic pulse_a(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); #1; ev_a = 1'b1; idle(4);
            @(negedge clk); #1; ev_a = 1'b0; idle(4);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1 rst_n = 1'b1;
        // R1: reset values
        for (int a = 0; a < 4; a++) begin
            @(negedge clk); #1 addr = 2'(a); #1;
            check("R1 reset reg", rdata, 16'h0000);
        end
        check("R1 reset outs", {13'b0, pwm_out, irq_a, irq_b}, 16'h0000);

        // R4/R5: waveform with A=5, B=3
        wr(1, 16'd5); wr(2, 16'd3); wr(0, 16'd2);
        wr(3, 16'h0039);
        @(negedge clk); #1 addr = 3; #1;
        check("R2 ctl readback", rdata, 16'h0039);
        idle(40);
        // R8: clear both pendings
        wr(3, 16'h00F9);
        idle(12);
        // R2: software write overrides running count
        wr(0, 16'd100);
        @(negedge clk); #1 addr = 0; #1;
        check("R2 write override", rdata, 16'd99);
        // R3: stop, counter holds
        wr(3, 16'h0030);
        idle(6);

        // R6: event count, rising edges, A=4 cnt=2, 8 edges -> 4 with pending A
        wr(1, 16'd4); wr(0, 16'd2); wr(3, 16'h00DA);
        pulse_a(8);
        @(negedge clk); #1 addr = 0; #1;
        check("R6 event count", rdata, 16'd4);
        @(negedge clk); #1 addr = 3; #1;
        check("R6 pending A", {15'b0, rdata[6]}, 16'd1);
        // falling-edge select
        wr(3, 16'h01DA);
        pulse_a(3);

        // R7: capture, B on falling edge
        wr(0, 16'd500);
        wr(3, 16'h02FB);
        idle(5);
        @(negedge clk); #1 ev_b = 1'b1; idle(6);
        pulse_a(2);
        @(negedge clk); #1 ev_b = 1'b0; idle(8);
        @(negedge clk); #1 addr = 3; #1;
        check("R7 pending B", {15'b0, rdata[7]}, 16'd1);

        // R3: invalid mode code with run set holds the counter
        wr(3, 16'h000F);
        idle(6);
        // back to waveform to exercise the low-to-high reload again
        wr(1, 16'd1); wr(2, 16'd2); wr(0, 16'd0); wr(3, 16'h0039);
        idle(30);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule